// File: doc/BRIEF.md
# Dual Prescaler Timing Configuration Register

This block holds one 4-bit timing configuration write port that feeds two separate prescalers: one that paces a watchdog and one that paces a cyclic-sense function. Each write carries a target select bit and a 3-bit code. Only the selected prescaler takes the new code, and the other prescaler keeps its current code. During the write cycle, the read-back data port shows the watchdog status nibble that arrives on an input.

Each stored code decodes to a divide ratio from a non-binary set: 1, 2, 4, 6, 8, 10, 12 or 14. A divider per prescaler counts the cycles in which a shared base tick input is high. It emits a one-clock enable tick every N counted base ticks. The watchdog divider uses its decoded ratio only while windowed watchdog mode is active. Outside that mode it passes every base tick through.

The watchdog window logic, the cyclic-sense wake-up behaviour and the oscillator that produces the base tick are outside this block.

Top module: `pscl_cfg_top`

## Requirements
- R1: While reset is asserted, and after it is released with no write, both stored codes read 0 and both tick outputs are low.
- R2: A write with `wr_data_i[3]`=1 loads `wr_data_i[2:0]` into the cyclic-sense code, visible on `cs_code_o` one clock later. The watchdog code is unchanged.
- R3: A write with `wr_data_i[3]`=0 loads `wr_data_i[2:0]` into the watchdog code, visible on `wd_code_o` one clock later. The cyclic-sense code is unchanged.
- R4: In a cycle without `wr_en_i`, neither stored code changes.
- R5: `rd_data_o` equals `wd_status_i` in every cycle in which `wr_en_i` is high, and is 0 otherwise.
- R6: Code 0 gives a divide ratio of 1. Any code k from 1 to 7 gives a ratio of 2k. The same mapping applies to both prescalers.
- R7: With ratio N, a divider's tick output is high for exactly the one clock that follows every Nth counted base tick. Counting restarts from the last load.
- R8: A divider counts only the cycles in which `base_tick_i` is high. Its tick output is never high unless `base_tick_i` was high in the previous cycle.
- R9: A write to one prescaler clears that divider's count. A base tick in the same cycle as that write is not counted for it. The other divider keeps counting without disturbance.
- R10: While `win_mode_i` is 0, the watchdog divider ticks after every base tick whatever its code. The cyclic-sense divider still uses its decoded ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for the configuration register |
| wr_data_i | input | 4 | Bit 3 selects the target (1 cyclic-sense, 0 watchdog); bits 2:0 carry the code |
| wd_status_i | input | 4 | Watchdog status nibble returned on a write |
| win_mode_i | input | 1 | Windowed watchdog mode active |
| base_tick_i | input | 1 | Base tick, one clock wide per tick |
| rd_data_o | output | 4 | Read-back data during a write |
| wd_code_o | output | 3 | Stored watchdog code |
| cs_code_o | output | 3 | Stored cyclic-sense code |
| wd_tick_o | output | 1 | Watchdog prescaler enable tick |
| cs_tick_o | output | 1 | Cyclic-sense prescaler enable tick |

## Verification
The assertions check on every cycle that:
- the routing of a write into one code field leaves the other field alone;
- the codes hold when there is no write;
- the read-back port shows the status nibble during a write and 0 otherwise;
- no tick appears without a base tick in the cycle before.

The exact divide periods cannot be expressed as simple cycle properties. These are:
- the non-binary ratio table;
- counting across gaps in the base tick;
- the counter clear on a reload;
- the undivided watchdog outside windowed mode.

The bench shows these by sweeping every code on both prescalers, with dense and sparse base-tick patterns, and by comparing each cycle against periods computed arithmetically.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int CODE_W  = 3;
  localparam int RATIO_W = CODE_W + 2;
  localparam int NUM_CH  = 2;

  typedef enum logic [0:0] {CH_WD = 1'b0, CH_CS = 1'b1} pscl_ch_e;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  // code 0 -> 1, code k -> 2k
  function automatic ratio_t code_to_ratio(input code_t code);
    ratio_t r;
    if (code == '0) r = ratio_t'(1);
    else            r = ratio_t'({code, 1'b0});
    return r;
  endfunction
endpackage

// File: rtl/pscl_rst_sync.sv
module pscl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pscl_cfg_reg.sv
module pscl_cfg_reg
  import pscl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CODE_W:0]   wr_data_i,
  output code_t             code_o [NUM_CH],
  output logic [NUM_CH-1:0] load_o
);
  code_t             code_q [NUM_CH];
  code_t             code_d [NUM_CH];
  logic [NUM_CH-1:0] load_d;
  pscl_ch_e          sel;

  always_comb begin
    sel = pscl_ch_e'(wr_data_i[CODE_W]);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_field
    always_comb begin
      load_d[ch] = wr_en_i && (sel == pscl_ch_e'(ch));
      code_d[ch] = code_q[ch];
      if (load_d[ch]) code_d[ch] = wr_data_i[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          code_q[ch] <= '0;
      else if (load_d[ch]) code_q[ch] <= code_d[ch];
    end

    assign code_o[ch] = code_q[ch];
  end

  assign load_o = load_d;
endmodule

// File: rtl/pscl_divider.sv
module pscl_divider
  import pscl_pkg::*;
#(
  parameter int CNT_W = RATIO_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_i,
  input  logic   base_tick_i,
  input  ratio_t ratio_i,
  output logic   tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             cnt_en;
  logic             at_end;

  always_comb begin
    at_end = ({{(32-CNT_W){1'b0}}, cnt_q} >= (32'(ratio_i) - 32'd1));
    cnt_en = clr_i || base_tick_i;
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (base_tick_i) begin
      if (at_end) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pscl_cfg_top.sv
module pscl_cfg_top
  import pscl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CODE_W:0]   wr_data_i,
  input  logic [CODE_W:0]   wd_status_i,
  input  logic              win_mode_i,
  input  logic              base_tick_i,
  output logic [CODE_W:0]   rd_data_o,
  output logic [CODE_W-1:0] wd_code_o,
  output logic [CODE_W-1:0] cs_code_o,
  output logic              wd_tick_o,
  output logic              cs_tick_o
);
  logic              rst_n_s;
  code_t             code [NUM_CH];
  logic [NUM_CH-1:0] load;
  ratio_t            ratio [NUM_CH];
  logic [NUM_CH-1:0] tick;

  pscl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  pscl_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .code_o    (code),
    .load_o    (load)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_div
    if (ch == int'(CH_WD)) begin : g_wd_ratio
      always_comb ratio[ch] = win_mode_i ? code_to_ratio(code[ch]) : ratio_t'(1);
    end else begin : g_cs_ratio
      always_comb ratio[ch] = code_to_ratio(code[ch]);
    end

    pscl_divider #(.CNT_W(RATIO_W)) u_div (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .clr_i       (load[ch]),
      .base_tick_i (base_tick_i),
      .ratio_i     (ratio[ch]),
      .tick_o      (tick[ch])
    );
  end

  always_comb begin
    rd_data_o = wr_en_i ? wd_status_i : '0;
  end

  assign wd_code_o = code[CH_WD];
  assign cs_code_o = code[CH_CS];
  assign wd_tick_o = tick[CH_WD];
  assign cs_tick_o = tick[CH_CS];
endmodule

// File: rtl/pscl_cfg_chk.sv
module pscl_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [3:0] wr_data_i,
  input logic [3:0] wd_status_i,
  input logic       base_tick_i,
  input logic [3:0] rd_data_o,
  input logic [2:0] wd_code_o,
  input logic [2:0] cs_code_o,
  input logic       wd_tick_o,
  input logic       cs_tick_o
);
  AST_CS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_data_i[3] |=> (cs_code_o == $past(wr_data_i[2:0])) && $stable(wd_code_o)); // R2

  AST_WD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !wr_data_i[3] |=> (wd_code_o == $past(wr_data_i[2:0])) && $stable(cs_code_o)); // R3

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(wd_code_o) && $stable(cs_code_o)); // R4

  AST_RDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o == (wr_en_i ? wd_status_i : 4'h0)); // R5

  AST_WD_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    wd_tick_o |-> $past(base_tick_i)); // R8

  AST_CS_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cs_tick_o |-> $past(base_tick_i)); // R8
endmodule

bind pscl_cfg_top pscl_cfg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .wd_status_i (wd_status_i),
  .base_tick_i (base_tick_i),
  .rd_data_o   (rd_data_o),
  .wd_code_o   (wd_code_o),
  .cs_code_o   (cs_code_o),
  .wd_tick_o   (wd_tick_o),
  .cs_tick_o   (cs_tick_o)
);

// File: tb/tb_pscl_cfg_top.sv
module tb_pscl_cfg_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_data;
  logic [3:0] wd_status;
  logic       win_mode;
  logic       base_tick;
  logic [3:0] rd_data;
  logic [2:0] wd_code, cs_code;
  logic       wd_tick, cs_tick;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pscl_cfg_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wd_status_i(wd_status), .win_mode_i(win_mode), .base_tick_i(base_tick),
    .rd_data_o(rd_data), .wd_code_o(wd_code), .cs_code_o(cs_code),
    .wd_tick_o(wd_tick), .cs_tick_o(cs_tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ratio_of(input int code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

  // one cycle: drive at negedge, then sample at the next negedge
  task automatic cyc(input logic we, input logic [3:0] d, input logic bt);
    wr_en = we; wr_data = d; base_tick = bt;
    #1;
    if (we) chk("R5 rd_data in write", int'(rd_data), int'(wd_status));
    else    chk("R5 rd_data idle", int'(rd_data), 0);
    @(negedge clk);
  endtask

  task automatic sweep(input int ch, input int code, input int gap, input logic win);
    int n, old_other;
    logic t;
    win_mode = win;
    wd_status = 4'(code + ch * 8);
    old_other = (ch == 1) ? int'(wd_code) : int'(cs_code);
    cyc(1'b1, {ch[0], 3'(code)}, 1'b0);
    if (ch == 1) begin
      chk("R2 cs code loaded", int'(cs_code), code);
      chk("R2 wd code kept", int'(wd_code), old_other);
    end else begin
      chk("R3 wd code loaded", int'(wd_code), code);
      chk("R3 cs code kept", int'(cs_code), old_other);
    end
    n = (ch == 0 && !win) ? 1 : ratio_of(code);
    for (int k = 0; k < 30; k++) begin
      cyc(1'b0, 4'h0, 1'b1);
      t = (ch == 1) ? cs_tick : wd_tick;
      if (ch == 0 && !win) chk("R10 wd undivided", int'(t), 1);
      else chk("R6 R7 tick period", int'(t), ((k + 1) % n == 0) ? 1 : 0);
      for (int g = 0; g < gap; g++) begin
        cyc(1'b0, 4'h0, 1'b0);
        t = (ch == 1) ? cs_tick : wd_tick;
        chk("R8 no tick without base", int'(t), 0);
      end
    end
    chk("R4 codes held", int'((ch == 1) ? cs_code : wd_code), code);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 4'h0; wd_status = 4'h0;
    win_mode = 1'b1; base_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 wd code in reset", int'(wd_code), 0);
    chk("R1 cs code in reset", int'(cs_code), 0);
    chk("R1 ticks in reset", int'(wd_tick | cs_tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 wd code after reset", int'(wd_code), 0);
    chk("R1 cs code after reset", int'(cs_code), 0);
    chk("R1 ticks after reset", int'(wd_tick | cs_tick), 0);

    for (int ch = 0; ch < 2; ch++)
      for (int code = 0; code < 8; code++)
        for (int gap = 0; gap < 3; gap += 2)
          sweep(ch, code, gap, 1'b1);

    // R10: window mode off, watchdog ignores code, cyclic-sense still divides
    for (int code = 0; code < 8; code++) sweep(0, code, 1, 1'b0);
    win_mode = 1'b0;
    sweep(1, 3, 0, 1'b0);

    // R9: reload clears only the written divider, base tick in write cycle ignored
    win_mode = 1'b1;
    cyc(1'b1, 4'b1001, 1'b0);        // cs code 1 -> ratio 2
    cyc(1'b1, 4'b0010, 1'b0);        // wd code 2 -> ratio 4
    cyc(1'b0, 4'h0, 1'b1);           // wd cnt 1, cs cnt 1
    cyc(1'b0, 4'h0, 1'b1);           // wd cnt 2, cs wraps
    chk("R9 cs tick before reload", int'(cs_tick), 1);
    cyc(1'b0, 4'h0, 1'b1);           // wd cnt 3, cs cnt 1
    cyc(1'b1, 4'b0010, 1'b1);        // reload wd with base high
    chk("R9 wd cleared, no tick", int'(wd_tick), 0);
    chk("R9 cs undisturbed", int'(cs_tick), 1);
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 4'h0, 1'b1);
      chk("R9 wd restarts from zero", int'(wd_tick), (k == 3) ? 1 : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule